// File: doc/BRIEF.md
# PRBS7 Link Self-Test Generator and Checker

This block runs a built-in bit-error-rate test on a link that carries 10 bits per word. It sits between the protocol logic and the serializer.

While the test enable is low, the transmit word from the protocol logic goes to the serializer unchanged. A narrow-mode select keeps only the low five bits of that word and drives the upper five bits to zero. While the test enable is high, both the transmit word and the narrow select are ignored. In their place the block sends ten bits per clock of a maximal-length pseudo-random sequence of period 127. The generating polynomial is x^7 + x^6 + 1. Bit 0 of each word holds the earliest bit.

The same enable turns on a receive checker. The checker takes its 7-bit register from the first received word after enable, so it locks to whatever phase of the sequence arrives. It then predicts every later bit and drives a pass flag. A hold select picks how the flag behaves:
- Hold select low: the flag follows the result of each word.
- Hold select high: the flag stays low after the first mismatch until the enable drops.

Top module: `prbs7_link_bist`

## Requirements
- R1: During reset, and after it, `pass_o` is 1 and `tx_data_o` is 0 until the first clock edge after reset.
- R2: With `test_en` = 0 and `narrow_sel` = 0, `tx_data_o` equals the `tx_data_i` sampled at the previous clock edge.
- R3: With `test_en` = 0 and `narrow_sel` = 1, `tx_data_o[4:0]` equals the previous `tx_data_i[4:0]` and `tx_data_o[9:5]` is 0.
- R4: With `test_en` = 1, `tx_data_o` carries the sequence ten bits per word, with the earliest bit in bit 0. The first word appears after the first enabled edge. `tx_data_i` and `narrow_sel` have no effect.
- R5: The transmitted bits follow b[n] = b[n-6] XOR b[n-7]. The seed register starts at 7'h01 with its bit 6 as the oldest bit. The bit stream therefore repeats every 127 bits.
- R6: The checker loads its register from bits 0 to 6 of the first received word after enable and compares only bits 7 to 9 of that word. Any phase of the sequence is accepted.
- R7: With `test_en` = 1 and `fail_hold` = 0, `pass_o` after each clock edge is 0 exactly when the word sampled at that edge held at least one mispredicted bit.
- R8: With `test_en` = 1 and `fail_hold` = 1, once a mismatch is seen, `pass_o` stays 0 for as long as the enable stays high.
- R9: When `test_en` goes low, `pass_o` returns to 1 at the next edge and any held failure is cleared. A later enable restarts the generator from its seed and the checker from a fresh lock.
- R10: With `test_en` = 0, `pass_o` stays 1 whatever arrives on `rx_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Enables generator and checker |
| fail_hold | input | 1 | 1: pass flag holds low after any error |
| narrow_sel | input | 1 | Normal-path 5-bit mode (ignored under test) |
| tx_data_i | input | 10 | Transmit word from protocol logic |
| tx_data_o | output | 10 | Word to the serializer |
| rx_data_i | input | 10 | Received word, bit 0 earliest |
| pass_o | output | 1 | 1 = no error; 0 = error |

## Verification
The bench feeds the checker the sequence at a random phase offset, which exposes a checker that assumes the transmitter's own phase and so fails on every word. It injects single-bit errors into random words. A checker that shifted received bits instead of predicted bits would then report a burst of failures where it should report one. It also flips a bit in the compared tail of the first word, which catches a lock that skips checking of the first word. It disables the test in the middle of a held failure, which catches a flag that never clears. It runs more than 127 words so that a wrong tap or a wrong bit order drifts away from the expected stream.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;

    localparam int WORD_W   = 10;
    localparam int LFSR_W   = 7;
    localparam int TAP_HI   = 6;
    localparam int TAP_LO   = 5;
    localparam int NARROW_W = 5;
    localparam int LOAD_N   = LFSR_W;
    localparam logic [LFSR_W-1:0] DEF_SEED = 7'h01;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        lfsr_t st;
        word_t word;
    } gen_step_t;

    typedef struct packed {
        lfsr_t st;
        logic  err;
    } chk_step_t;

    function automatic logic fb_bit(input lfsr_t s);
        return s[TAP_HI] ^ s[TAP_LO];
    endfunction

    function automatic gen_step_t gen_word(input lfsr_t s_in);
        gen_step_t r;
        lfsr_t     s;
        logic      b;
        s      = s_in;
        r.word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            b         = fb_bit(s);
            r.word[i] = b;
            s         = {s[LFSR_W-2:0], b};
        end
        r.st = s;
        return r;
    endfunction

    function automatic chk_step_t check_word(input lfsr_t s_in, input word_t rx,
                                             input logic locked);
        chk_step_t r;
        lfsr_t     s;
        logic      pred;
        s     = s_in;
        r.err = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (!locked && i < LOAD_N) begin
                s = {s[LFSR_W-2:0], rx[i]};
            end else begin
                pred = fb_bit(s);
                if (pred != rx[i]) r.err = 1'b1;
                s = {s[LFSR_W-2:0], pred};
            end
        end
        r.st = s;
        return r;
    endfunction

endpackage

// File: rtl/prbs7_tx_path.sv
module prbs7_tx_path
    import prbs7_pkg::*;
#(
    parameter lfsr_t SEED = DEF_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    input  logic  narrow_sel,
    input  word_t tx_data_i,
    output word_t tx_data_o
);
    lfsr_t     gen_st;
    word_t     tx_q;
    word_t     normal_w;
    gen_step_t step;

    always_comb begin
        step = gen_word(gen_st);
        if (narrow_sel) normal_w = {{(WORD_W-NARROW_W){1'b0}}, tx_data_i[NARROW_W-1:0]};
        else            normal_w = tx_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_st <= SEED;
            tx_q   <= '0;
        end else if (test_en) begin
            gen_st <= step.st;
            tx_q   <= step.word;
        end else begin
            gen_st <= SEED;
            tx_q   <= normal_w;
        end
    end

    assign tx_data_o = tx_q;

    AST_GEN_STATE_LIVE: assert property (@(posedge clk) disable iff (rst)
        gen_st != '0);  // R5
    AST_TX_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !narrow_sel) |=> tx_data_o == $past(tx_data_i));  // R2
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!test_en && narrow_sel) |=> tx_data_o[WORD_W-1:NARROW_W] == '0);  // R3
endmodule

// File: rtl/prbs7_rx_check.sv
module prbs7_rx_check
    import prbs7_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    input  word_t rx_data_i,
    output logic  word_err
);
    lfsr_t     chk_st;
    logic      locked;
    chk_step_t step;

    always_comb begin
        step     = check_word(chk_st, rx_data_i, locked);
        word_err = test_en && step.err;
    end

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            chk_st <= '0;
            locked <= 1'b0;
        end else begin
            chk_st <= step.st;
            locked <= 1'b1;
        end
    end

    AST_LOCK_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        test_en |=> locked);  // R6
    AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> !word_err);  // R10
endmodule

// File: rtl/prbs7_pass_flag.sv
module prbs7_pass_flag (
    input  logic clk,
    input  logic rst,
    input  logic test_en,
    input  logic fail_hold,
    input  logic word_err,
    output logic pass_o
);
    logic seen_q;
    logic pass_q;

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            seen_q <= 1'b0;
            pass_q <= 1'b1;
        end else begin
            seen_q <= seen_q | word_err;
            pass_q <= fail_hold ? !(seen_q | word_err) : !word_err;
        end
    end

    assign pass_o = pass_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (test_en && fail_hold && !pass_o) |=> !pass_o);  // R8
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> pass_o);  // R9
    AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (test_en && !fail_hold) |=> pass_o == !$past(word_err));  // R7
endmodule

// File: rtl/prbs7_link_bist.sv
module prbs7_link_bist
    import prbs7_pkg::*;
#(
    parameter logic [6:0] SEED = DEF_SEED
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       test_en,
    input  logic       fail_hold,
    input  logic       narrow_sel,
    input  logic [9:0] tx_data_i,
    output logic [9:0] tx_data_o,
    input  logic [9:0] rx_data_i,
    output logic       pass_o
);
    logic word_err;

    prbs7_tx_path #(.SEED(SEED)) u_tx (
        .clk(clk), .rst(rst), .test_en(test_en), .narrow_sel(narrow_sel),
        .tx_data_i(tx_data_i), .tx_data_o(tx_data_o)
    );

    prbs7_rx_check u_chk (
        .clk(clk), .rst(rst), .test_en(test_en),
        .rx_data_i(rx_data_i), .word_err(word_err)
    );

    prbs7_pass_flag u_flag (
        .clk(clk), .rst(rst), .test_en(test_en), .fail_hold(fail_hold),
        .word_err(word_err), .pass_o(pass_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pass_o && tx_data_o == '0));  // R1
endmodule

// File: tb/prbs7_link_bist_bench.sv
module prbs7_link_bist_bench;
    logic       clk = 0;
    logic       rst;
    logic       test_en, fail_hold, narrow_sel;
    logic [9:0] tx_data_i, rx_data_i;
    logic [9:0] tx_data_o;
    logic       pass_o;

    int checks = 0;
    int fails  = 0;
    logic seq [0:2047];

    always #10 clk = ~clk;

    prbs7_link_bist u_prbs7_link_bist (
        .clk(clk), .rst(rst), .test_en(test_en), .fail_hold(fail_hold),
        .narrow_sel(narrow_sel), .tx_data_i(tx_data_i), .tx_data_o(tx_data_o),
        .rx_data_i(rx_data_i), .pass_o(pass_o)
    );

    function automatic logic [9:0] word_at(input int idx);
        logic [9:0] w;
        for (int i = 0; i < 10; i++) w[i] = seq[idx + i];
        return w;
    endfunction

    task automatic check_tx(input string req, input logic [9:0] exp);
        checks++;
        if (tx_data_o !== exp) begin
            fails++;
            $display("FAIL %s tx_data_o actual=%h expected=%h", req, tx_data_o, exp);
        end
    endtask

    task automatic check_pass(input string req, input logic exp);
        checks++;
        if (pass_o !== exp) begin
            fails++;
            $display("FAIL %s pass_o actual=%b expected=%b", req, pass_o, exp);
        end
    endtask

    task automatic step(input logic en, input logic hold, input logic nar,
                        input logic [9:0] txd, input logic [9:0] rxw);
        test_en    = en;
        fail_hold  = hold;
        narrow_sel = nar;
        tx_data_i  = txd;
        rx_data_i  = rxw;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // Reference stream: seed 7'h01, bit 6 is oldest (R5)
        for (int k = 0; k < 7; k++) seq[k] = (k == 6);
        for (int k = 7; k < 2048; k++) seq[k] = seq[k-6] ^ seq[k-7];

        rst = 1; test_en = 0; fail_hold = 0; narrow_sel = 0;
        tx_data_i = 10'h3A5; rx_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_pass("R1", 1'b1);
        check_tx("R1", 10'h000);
        rst = 0;

        // Disabled: passthrough, narrow mode, pass stays high (R2 R3 R10)
        for (int n = 0; n < 30; n++) begin
            logic [9:0] d;
            logic       nr;
            d  = 10'($urandom);
            nr = 1'($urandom);
            step(0, 1'($urandom), nr, d, 10'($urandom));
            if (nr) check_tx("R3", {5'b0, d[4:0]});
            else    check_tx("R2", d);
            check_pass("R10", 1'b1);
        end

        // Enabled, live mode, random phase, random single-bit errors (R4 R5 R6 R7)
        begin
            int off;
            off = $urandom_range(0, 126);
            for (int m = 0; m < 140; m++) begin
                logic [9:0] flip;
                flip = '0;
                if (m >= 1 && $urandom_range(0, 7) == 0) flip = 10'(1 << $urandom_range(0, 9));
                step(1, 0, 1'($urandom), 10'($urandom), word_at(off + 10*m) ^ flip);
                check_tx((m >= 127) ? "R5" : "R4", word_at(7 + 10*m));
                check_pass((m == 0) ? "R6" : "R7", flip == '0);
            end
        end

        // Disable: pass high, normal path back (R9)
        step(0, 0, 0, 10'h155, '0);
        check_pass("R9", 1'b1);
        check_tx("R9", 10'h155);

        // Hold mode: one error at word 30 (R8)
        begin
            int off;
            off = $urandom_range(0, 126);
            for (int m = 0; m < 60; m++) begin
                logic [9:0] flip;
                flip = (m == 30) ? 10'(1 << $urandom_range(0, 9)) : '0;
                step(1, 1, 0, '0, word_at(off + 10*m) ^ flip);
                check_pass("R8", m < 30);
            end
        end

        // Drop enable in the middle of a held failure, then restart clean (R9)
        step(0, 1, 0, 10'h0F0, '0);
        check_pass("R9", 1'b1);
        begin
            int off;
            off = $urandom_range(0, 126);
            for (int m = 0; m < 20; m++) begin
                step(1, 1, 0, 10'($urandom), word_at(off + 10*m));
                check_pass("R9", 1'b1);
                check_tx("R9", word_at(7 + 10*m));
            end
        end

        // Error in the compared tail of the first word (R6)
        step(0, 0, 0, '0, '0);
        begin
            int off;
            off = 41;
            step(1, 0, 0, '0, word_at(off) ^ 10'h100);
            check_pass("R6", 1'b0);
            step(1, 0, 0, '0, word_at(off + 10));
            check_pass("R6", 1'b1);
        end

        // Disabled with garbage input keeps pass high (R10)
        step(0, 0, 0, '0, 10'h3FF);
        step(0, 1, 0, '0, 10'h2AA);
        check_pass("R10", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule